// File: doc/BRIEF.md
# Pipelined Multibit Trie Route Lookup

This block resolves the longest matching prefix for a destination address. It walks a multibit trie that has already been flattened into one table per pipeline stage. The address is consumed most significant bits first, a fixed number of bits (the stride) per stage. Each stage reads one entry from its own table. An entry is either a final action/port identifier or a pointer into the next stage's table. Once a stage has produced a final identifier, every later stage forwards it unchanged. As a result, every lookup spends the same number of cycles in the pipe, whatever depth its prefix has.

A new search can be accepted on every clock cycle, and one completes on every cycle. An external controller builds the trie contents and loads them through a write port that targets one stage table per cycle. If the last stage still produces a pointer, the trie is malformed. A write that lands on a stage in the same cycle a lookup needs that stage's table also makes the result unusable. Both cases are reported with an error flag instead of a port value.

Top module: `trie_lookup_pipe`

## Requirements
- R1: A table entry is one flag bit above a FIELD_W-bit field. Flag 0 means the field is the final port identifier. Flag 1 means the field is a pointer, and only its low PTR_W bits take part in the next stage's index.
- R2: Stage 0 has exactly 2^STRIDE entries and is indexed by the STRIDE most significant address bits alone.
- R3: Stage i>0 is indexed by {pointer from stage i-1, address bits [ADDR_W-1-i*STRIDE -: STRIDE]}. Each stage hands on the address with its consumed bits removed, so nothing remains after the last stage.
- R4: When an earlier stage has already produced a final identifier, the later stages forward it unchanged, and the contents of their tables have no effect on it.
- R5: With NSTAGE = ADDR_W/STRIDE, the result of a request accepted at a clock edge appears exactly NSTAGE edges later. Back-to-back requests give back-to-back results.
- R6: res_valid is 0 after reset and on every cycle that does not carry the result of an accepted request. res_port reads 0 whenever res_valid is 0.
- R7: If the entry leaving the last stage still has flag 1, the result is given with res_err=1 and res_port=0.
- R8: With wr_en=1, the entry {wr_ptr_flag, wr_field} is written to stage wr_stage at wr_index, and later lookups see it from the next cycle on. For stage 0, only wr_index[STRIDE-1:0] is used, and a write whose upper index bits are not zero is ignored.
- R9: An accepted write takes priority over its stage's read in the same cycle. A lookup that needed that read ends with res_err=1. Lookups in other stages, and lookups passing through that stage with a result already found, are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A search request is presented this cycle |
| req_addr | input | ADDR_W | Address to be looked up |
| wr_en | input | 1 | Table write strobe |
| wr_stage | input | STG_W | Stage whose table is written |
| wr_index | input | PTR_W+STRIDE | Entry index inside that table |
| wr_ptr_flag | input | 1 | Flag bit of the written entry |
| wr_field | input | FIELD_W | Port identifier or pointer of the written entry |
| res_valid | output | 1 | A lookup result is presented this cycle |
| res_port | output | FIELD_W | Resolved action/port identifier |
| res_err | output | 1 | The lookup hit a malformed trie or a write collision |

## Verification
The bench builds the block with ADDR_W=12, STRIDE=4, FIELD_W=6 and PTR_W=2. That gives three stages, a 16-entry root table and two 64-entry tables, small enough for every entry to be loaded and modelled. At this size, addresses that terminate at each of the three depths, the malformed last-stage pointer and writes that collide with reads at each stage can all be reached in a few hundred cycles. The pointer entries carry nonzero upper field bits, which exposes any use of bits beyond PTR_W.

// File: rtl/trie_pkg.sv
package trie_pkg;

  // Number of pipeline stages needed to consume the whole address.
  function automatic int stage_total(input int addr_w, input int stride);
    return addr_w / stride;
  endfunction

  // Width of a stage selector for n stages (at least one bit).
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of the in-flight counter used by the top-level checks.
  function automatic int flight_width(input int n);
    return $clog2(n + 2) + 1;
  endfunction

endpackage

// File: rtl/trie_table.sv
module trie_table #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // The single port either writes or reads; a write wins.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end

  // R9
  wr_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $stable(rdata));

endmodule

// File: rtl/trie_stage.sv
module trie_stage
  import trie_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STRIDE  = 4,
  parameter int FIELD_W = 15,
  parameter int PTR_W   = 5,
  parameter bit FIRST   = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_flag,
  input  logic [FIELD_W-1:0]        in_field,
  input  logic                      in_err,
  input  logic [ADDR_W-1:0]         in_addr,
  input  logic                      wr_hit,
  input  logic [PTR_W+STRIDE-1:0]   wr_index,
  input  logic                      wr_flag,
  input  logic [FIELD_W-1:0]        wr_field,
  output logic                      out_valid,
  output logic                      out_flag,
  output logic [FIELD_W-1:0]        out_field,
  output logic                      out_err,
  output logic [ADDR_W-1:0]         out_addr
);
  localparam int FULL_W  = PTR_W + STRIDE;
  localparam int TBL_W   = FIRST ? STRIDE : FULL_W;
  localparam int ENTRY_W = FIELD_W + 1;

  logic [STRIDE-1:0]  nib;
  logic [TBL_W-1:0]   rd_idx;
  logic [TBL_W-1:0]   wr_idx;
  logic               wr_ok;
  logic               need_read;
  logic               tbl_we;
  logic               tbl_re;
  logic               collide;
  logic [ENTRY_W-1:0] rd_data;

  logic               valid_q;
  logic               sel_q;
  logic               err_q;
  logic               pass_flag_q;
  logic [FIELD_W-1:0] pass_field_q;
  logic [ADDR_W-1:0]  addr_q;

  // Next stride of address bits, always at the top of the shifted address.
  assign nib = in_addr[ADDR_W-1 -: STRIDE];

  generate
    if (FIRST) begin : g_root
      assign rd_idx = nib;
      assign wr_idx = wr_index[STRIDE-1:0];
      assign wr_ok  = (wr_index[FULL_W-1:STRIDE] == '0);
    end else begin : g_inner
      assign rd_idx = {in_field[PTR_W-1:0], nib};
      assign wr_idx = wr_index;
      assign wr_ok  = 1'b1;
    end
  endgenerate

  // The root stage always reads; later stages read only on a pointer.
  assign need_read = in_valid && (FIRST || in_flag);
  assign tbl_we    = wr_hit && wr_ok;
  assign collide   = need_read && tbl_we;
  assign tbl_re    = need_read && !tbl_we;

  trie_table #(
    .IDX_W  (TBL_W),
    .DATA_W (ENTRY_W)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (wr_idx),
    .wdata ({wr_flag, wr_field}),
    .re    (tbl_re),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q      <= 1'b0;
      sel_q        <= 1'b0;
      err_q        <= 1'b0;
      pass_flag_q  <= 1'b0;
      pass_field_q <= '0;
      addr_q       <= '0;
    end else begin
      valid_q      <= in_valid;
      sel_q        <= tbl_re;
      err_q        <= in_valid && (in_err || collide);
      pass_flag_q  <= in_flag;
      pass_field_q <= in_field;
      addr_q       <= in_addr << STRIDE;
    end
  end

  // Forwarding mux sits behind the synchronous read.
  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_flag  = err_q ? 1'b0 : (sel_q ? rd_data[FIELD_W] : pass_flag_q);
  assign out_field = err_q ? '0 : (sel_q ? rd_data[FIELD_W-1:0] : pass_field_q);
  assign out_addr  = addr_q;

  generate
    if (!FIRST) begin : g_pass_chk
      // R4
      pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_flag && !in_err) |=>
          (out_valid && !out_flag && !out_err && (out_field == $past(in_field))));
    end
  endgenerate

  // R9
  collide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (need_read && tbl_we) |=> (out_valid && out_err && !out_flag));

endmodule

// File: rtl/trie_lookup_pipe.sv
module trie_lookup_pipe
  import trie_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STRIDE  = 4,
  parameter int FIELD_W = 15,
  parameter int PTR_W   = 5,
  localparam int NSTAGE = stage_total(ADDR_W, STRIDE),
  localparam int STG_W  = sel_width(NSTAGE),
  localparam int IDX_W  = PTR_W + STRIDE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               wr_en,
  input  logic [STG_W-1:0]   wr_stage,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic               wr_ptr_flag,
  input  logic [FIELD_W-1:0] wr_field,
  output logic               res_valid,
  output logic [FIELD_W-1:0] res_port,
  output logic               res_err
);
  localparam int CNT_W = flight_width(NSTAGE);

  logic               v_c   [NSTAGE+1];
  logic               f_c   [NSTAGE+1];
  logic [FIELD_W-1:0] fd_c  [NSTAGE+1];
  logic               err_c [NSTAGE+1];
  logic [ADDR_W-1:0]  a_c   [NSTAGE+1];
  logic [NSTAGE-1:0]  wr_hit_vec;

  assign v_c[0]   = req_valid;
  assign f_c[0]   = 1'b0;
  assign fd_c[0]  = '0;
  assign err_c[0] = 1'b0;
  assign a_c[0]   = req_addr;

  generate
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
      assign wr_hit_vec[i] = wr_en && (wr_stage == STG_W'(i));

      trie_stage #(
        .ADDR_W  (ADDR_W),
        .STRIDE  (STRIDE),
        .FIELD_W (FIELD_W),
        .PTR_W   (PTR_W),
        .FIRST   (i == 0)
      ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v_c[i]),
        .in_flag   (f_c[i]),
        .in_field  (fd_c[i]),
        .in_err    (err_c[i]),
        .in_addr   (a_c[i]),
        .wr_hit    (wr_hit_vec[i]),
        .wr_index  (wr_index),
        .wr_flag   (wr_ptr_flag),
        .wr_field  (wr_field),
        .out_valid (v_c[i+1]),
        .out_flag  (f_c[i+1]),
        .out_field (fd_c[i+1]),
        .out_err   (err_c[i+1]),
        .out_addr  (a_c[i+1])
      );
    end
  endgenerate

  // A pointer leaving the last stage means the trie is malformed.
  logic last_bad;
  assign last_bad  = err_c[NSTAGE] || f_c[NSTAGE];
  assign res_valid = v_c[NSTAGE];
  assign res_err   = res_valid && last_bad;
  assign res_port  = (res_valid && !last_bad) ? fd_c[NSTAGE] : '0;

  // Checker state: requests accepted but not yet retired.
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= '0;
    end else begin
      inflight <= inflight + CNT_W'(req_valid) - CNT_W'(res_valid);
    end
  end

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNT_W'(NSTAGE));

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (inflight != '0));

  // R3
  addr_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (a_c[NSTAGE] == '0));

  // R7
  err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_valid && (res_port == '0)));

endmodule

// File: tb/trie_lookup_pipe_tb.sv
`timescale 1ns/1ps
module trie_lookup_pipe_tb;
  localparam int AW = 12;
  localparam int ST = 4;
  localparam int FW = 6;
  localparam int PW = 2;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_stage = '0;
  logic [5:0]    wr_index = '0;
  logic          wr_ptr_flag = 1'b0;
  logic [FW-1:0] wr_field = '0;
  logic          res_valid;
  logic [FW-1:0] res_port;
  logic          res_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [FW:0]   tbl [NS][64];
  bit            q_v   [$];
  logic [AW-1:0] q_a   [$];
  logic [NS-1:0] q_hit [$];
  string         q_tag [$];

  always #10 clk = ~clk;

  trie_lookup_pipe #(
    .ADDR_W (AW), .STRIDE (ST), .FIELD_W (FW), .PTR_W (PW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
    .wr_en (wr_en), .wr_stage (wr_stage), .wr_index (wr_index),
    .wr_ptr_flag (wr_ptr_flag), .wr_field (wr_field),
    .res_valid (res_valid), .res_port (res_port), .res_err (res_err)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Walks the trie as the requirements describe it; hit marks write collisions.
  function automatic void predict(input logic [AW-1:0] a, input logic [NS-1:0] hit,
                                  output bit e_err, output logic [FW-1:0] e_port);
    logic [FW:0] ent;
    bit err;
    ent = tbl[0][{2'b00, a[AW-1 -: ST]}];
    err = hit[0];
    for (int i = 1; i < NS; i++) begin
      if (!err && ent[FW]) begin
        if (hit[i]) err = 1'b1;
        else ent = tbl[i][{ent[PW-1:0], a[AW-1-ST*i -: ST]}];
      end
    end
    e_err  = err || ent[FW];
    e_port = e_err ? '0 : ent[FW-1:0];
  endfunction

  task automatic step(input bit v, input logic [AW-1:0] a, input bit we, input int stg,
                      input int idx, input bit fl, input logic [FW-1:0] fd,
                      input string tag);
    logic [NS-1:0] h;
    logic [NS-1:0] tmp;
    bit ee;
    logic [FW-1:0] ep;
    @(negedge clk);
    if (q_v.size() == NS) begin
      bit pv;
      logic [AW-1:0] pa;
      logic [NS-1:0] ph;
      string pt;
      pv = q_v.pop_front(); pa = q_a.pop_front(); ph = q_hit.pop_front(); pt = q_tag.pop_front();
      if (pv) begin
        predict(pa, ph, ee, ep);
        check(pt, "res_valid", 32'(res_valid), 32'd1);
        check(pt, "res_err", 32'(res_err), 32'(ee));
        check(pt, "res_port", 32'(res_port), 32'(ep));
      end else begin
        check(pt, "idle res_valid", 32'(res_valid), 32'd0);
        check(pt, "idle res_port", 32'(res_port), 32'd0);
      end
    end
    req_valid = v; req_addr = a; wr_en = we; wr_stage = stg[1:0];
    wr_index = idx[5:0]; wr_ptr_flag = fl; wr_field = fd;
    h = '0;
    if (we) begin
      if (stg == 0) h[0] = v && (idx < 16);
      else if (q_v.size() >= stg) begin
        tmp = q_hit[q_v.size() - stg];
        tmp[stg] = 1'b1;
        q_hit[q_v.size() - stg] = tmp;
      end
      if (!(stg == 0 && idx >= 16)) tbl[stg][idx] = {fl, fd};
    end
    q_v.push_back(v); q_a.push_back(a); q_hit.push_back(h); q_tag.push_back(tag);
  endtask

  task automatic look(input logic [AW-1:0] a, input string tag);
    step(1'b1, a, 1'b0, 0, 0, 1'b0, '0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 0, 0, 1'b0, '0, tag);
  endtask

  task automatic twrite(input int stg, input int idx, input bit fl, input logic [FW-1:0] fd,
                        input string tag);
    step(1'b0, '0, 1'b1, stg, idx, fl, fd, tag);
  endtask

  // Lookup plus a same-value rewrite of one entry: only the collision matters.
  task automatic look_wr(input bit v, input logic [AW-1:0] a, input int stg, input int idx,
                         input string tag);
    step(v, a, 1'b1, stg, idx, tbl[stg][idx][FW], tbl[stg][idx][FW-1:0], tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R5: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] lcg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R6", "reset res_valid", 32'(res_valid), 32'd0);
    check("R6", "reset res_port", 32'(res_port), 32'd0);

    // R8: load all three tables; R1: pointer fields carry set upper bits.
    for (int i = 0; i < 16; i++) begin
      if (i < 4) twrite(0, i, 1'b0, FW'(i + 10), "R8");
      else twrite(0, i, 1'b1, FW'(6'h3C | (i % 4)), "R8");
    end
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 16; n++) begin
        if (n < 8) twrite(1, p * 16 + n, 1'b0, FW'(p * 8 + n + 20), "R8");
        else twrite(1, p * 16 + n, 1'b1, FW'(6'h3C | (n % 4)), "R8");
      end
    end
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 16; n++) begin
        if (p == 3 && n == 15) twrite(2, p * 16 + n, 1'b1, 6'h3F, "R7");
        else twrite(2, p * 16 + n, 1'b0, FW'(p * 16 + n), "R8");
      end
    end
    repeat (NS) idle("R6");

    // R2: root-table results, R4: later bits must not matter.
    for (int t = 0; t < 4; t++) look({t[3:0], 8'hA5}, "R2");
    for (int t = 0; t < 4; t++) look({t[3:0], 8'h3C ^ 8'(t * 37)}, "R4");
    // R3 and R1: pointer walks ending at stage 1 or stage 2.
    for (int t = 4; t < 16; t++) look({t[3:0], 4'((t * 5) % 16), 4'((t * 7) % 16)}, "R3");
    for (int m = 8; m < 16; m++) look({4'h6, m[3:0], 4'(m)}, "R1");
    // R7: pointer leaves the last stage.
    look(12'h7FF, "R7");
    look(12'hFBF, "R7");
    look(12'h7FE, "R7");
    // R6: gaps between requests.
    for (int i = 0; i < 4; i++) begin
      look(12'h5A0 + 12'(i), "R6");
      idle("R6");
    end
    // R5: back-to-back burst.
    lcg = 12'h1D3;
    for (int i = 0; i < 10; i++) begin
      lcg = lcg * 12'd173 + 12'd59;
      look(lcg, "R5");
    end
    repeat (NS) idle("R6");

    // R8: rewrites seen by following lookups; upper root index bits block a write.
    twrite(2, 6, 1'b0, 6'h2A, "R8");
    look(12'h592, "R8");
    twrite(0, 0, 1'b0, 6'h11, "R8");
    look(12'h012, "R8");
    twrite(0, 17, 1'b0, 6'h33, "R8");
    look(12'h1F0, "R8");
    look(12'h0F0, "R8");
    repeat (NS) idle("R6");

    // R9: writes colliding with reads at each stage.
    look(12'h592, "R9");
    look(12'h4A0, "R9");
    look_wr(1'b1, 12'h123, 2, 6, "R9");
    look_wr(1'b1, 12'h300, 1, 3, "R9");
    look_wr(1'b1, 12'h4A0, 0, 4, "R9");
    look_wr(1'b0, 12'h000, 2, 0, "R9");
    look_wr(1'b0, 12'h000, 1, 0, "R9");
    look(12'h592, "R9");
    look_wr(1'b1, 12'h6C0, 1, 28, "R9");
    look(12'h9E1, "R9");
    repeat (NS + 1) idle("R6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule